// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a direct-mapped data cache placed between a processor port and a slower lower memory. A small fully associative buffer sits next to it. Every line pushed out of the main array goes into this buffer and is not thrown away. A request that misses the main array can therefore still be served without a trip to lower memory, as long as the line it wants was displaced recently.

Each lookup starts in the main array. A main hit answers in the same cycle the request is presented. On a main miss, the buffer compares the full line address against all of its entries at once. On a buffer hit, the wanted line and the line currently in its set trade places in one clock edge, and the request completes in its second cycle. If both stores miss, a line fill is requested from lower memory. The line that the fill displaces moves into the buffer: an empty buffer entry is used first, otherwise the entry that has waited longest. Writes update the cached word and are also sent straight to lower memory as single-word writes.

The requester holds `req_valid`, `req_addr`, `req_write` and `req_wdata` steady until `req_ready` is high. The transfer completes on the clock edge that ends that cycle.

Top module: `vc_dm_cache`

## Requirements
- R1: A read whose line is in the main array has `req_ready` high in the first cycle of the request. `rsp_rdata` in that cycle is the word selected by the low `OFF_W` address bits (word 0 in bits `WORD_W-1:0`).
- R2: The buffer holds `VICT_N` (default 4) lines, each tagged with its full line address `req_addr[ADDR_W-1:OFF_W]`. Lookups compare all entries in parallel, and at most one entry matches any address.
- R3: A request that misses the main array but hits the buffer raises `req_ready` in its second cycle and never raises `mem_req`.
- R4: On a buffer hit, the line that was in the main set moves into the buffer entry just freed. A later request for that line is again served in two cycles without `mem_req`.
- R5: A request that misses both stores raises `mem_req` from its second cycle, with `mem_addr` equal to its line address. `mem_req` stays high until a cycle with `mem_rsp_valid`, and `req_ready` rises in the cycle after that response.
- R6: A valid line displaced by a fill goes into the buffer and is later served as a buffer hit.
- R7: A displaced line goes into the lowest-numbered empty buffer entry. When no entry is empty, it replaces the entries in rotating order 0,1,2,3,…, so the line that entered the full buffer earliest is dropped first, and a request for it becomes a full miss.
- R8: A write completes with the same latency as a read of that address. In its completion cycle, `mem_wr` is high with `mem_wr_addr`/`mem_wr_data` equal to the request. Later reads of that word return the written value.
- R9: Reset empties both stores, so the first request for any address after reset is a full miss.
- R10: `req_ready` is never high without `req_valid`. After reset with no request, `req_ready`, `mem_req` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Write data |
| req_ready | output | 1 | Request completes this cycle |
| rsp_rdata | output | WORD_W | Read word, valid with `req_ready` |
| mem_req | output | 1 | Line fill request, held until response |
| mem_addr | output | ADDR_W-OFF_W | Line address of the fill |
| mem_rsp_valid | input | 1 | Fill data present |
| mem_rsp_line | input | WORD_W<<OFF_W | Fill line, word 0 in the low bits |
| mem_wr | output | 1 | Write-through strobe |
| mem_wr_addr | output | ADDR_W | Write-through word address |
| mem_wr_data | output | WORD_W | Write-through data |

## Verification
The bench builds the block with an 8-bit word address, 16-bit words, two-word lines, four sets and the four-entry buffer. With only 128 line addresses and 256 words, it can sweep every word of the address space and keep a full shadow of lower memory. A reference model of set contents, buffer contents and the rotating pointer predicts the latency class of every access. Random streams confined to 32 lines crowd eight lines onto each set, which forces swaps, fills into a full buffer and drops in every order. A directed six-line conflict run and a mid-run reset check the replacement order and the cleared state.

// File: rtl/vc_dm_cache.sv
module vc_dm_cache #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 32,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 4,
  parameter int VICT_N = 4,
  localparam int LA_W   = ADDR_W - OFF_W,
  localparam int LINE_W = WORD_W << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              mem_req,
  output logic [LA_W-1:0]   mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_line,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data
);
  localparam int SETS  = 1 << IDX_W;
  localparam int WPL   = 1 << OFF_W;
  localparam int TAG_W = LA_W - IDX_W;
  localparam int VP_W  = (VICT_N > 1) ? $clog2(VICT_N) : 1;

  logic [SETS-1:0]   m_vld;
  logic [TAG_W-1:0]  m_tag  [SETS];
  logic [LINE_W-1:0] m_line [SETS];
  logic [VICT_N-1:0] v_vld;
  logic [LA_W-1:0]   v_la   [VICT_N];
  logic [LINE_W-1:0] v_line [VICT_N];
  logic [VP_W-1:0]   v_ptr;
  logic              waiting;

  wire [LA_W-1:0]  la  = req_addr[ADDR_W-1:OFF_W];
  wire [IDX_W-1:0] idx = la[IDX_W-1:0];
  wire [TAG_W-1:0] tag = la[LA_W-1:IDX_W];
  wire [OFF_W-1:0] off = req_addr[OFF_W-1:0];

  wire [LINE_W-1:0] cur_line = m_line[idx];
  wire [LA_W-1:0]   evict_la = {m_tag[idx], idx};
  wire              m_hit    = m_vld[idx] && (m_tag[idx] == tag);

  logic [VICT_N-1:0] v_match;
  for (genvar i = 0; i < VICT_N; i++) begin : g_cmp
    assign v_match[i] = v_vld[i] && (v_la[i] == la);
  end

  logic            v_hit, v_any_free;
  logic [VP_W-1:0] v_sel, v_free, v_ins;
  always_comb begin
    v_hit      = |v_match;
    v_any_free = ~&v_vld;
    v_sel      = '0;
    v_free     = '0;
    for (int i = 0; i < VICT_N; i++)
      if (v_match[i]) v_sel = VP_W'(i);
    for (int i = VICT_N - 1; i >= 0; i--)
      if (!v_vld[i]) v_free = VP_W'(i);
    v_ins = v_any_free ? v_free : v_ptr;
  end

  wire lookup  = req_valid && !waiting;
  wire do_swap = lookup && !m_hit && v_hit;
  wire do_miss = lookup && !m_hit && !v_hit;
  wire do_fill = waiting && mem_rsp_valid;

  assign req_ready   = lookup && m_hit;
  assign mem_req     = waiting;
  assign mem_addr    = la;
  assign mem_wr      = req_ready && req_write;
  assign mem_wr_addr = req_addr;
  assign mem_wr_data = req_wdata;

  always_comb begin
    rsp_rdata = '0;
    for (int w = 0; w < WPL; w++)
      if (off == OFF_W'(w)) rsp_rdata = cur_line[w*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_vld   <= '0;
      v_vld   <= '0;
      v_ptr   <= '0;
      waiting <= 1'b0;
    end else begin
      if (do_miss) waiting <= 1'b1;
      if (do_fill) begin
        waiting    <= 1'b0;
        m_vld[idx] <= 1'b1;
        if (m_vld[idx]) begin
          v_vld[v_ins] <= 1'b1;
          if (!v_any_free)
            v_ptr <= (v_ptr == VP_W'(VICT_N - 1)) ? '0 : v_ptr + 1'b1;
        end
      end
      if (do_swap) begin
        v_vld[v_sel] <= m_vld[idx];
        m_vld[idx]   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      m_tag[idx]  <= tag;
      m_line[idx] <= mem_rsp_line;
      if (m_vld[idx]) begin
        v_la[v_ins]   <= evict_la;
        v_line[v_ins] <= cur_line;
      end
    end
    if (do_swap) begin
      m_tag[idx]    <= tag;
      m_line[idx]   <= v_line[v_sel];
      v_la[v_sel]   <= evict_la;
      v_line[v_sel] <= cur_line;
    end
    if (mem_wr)
      for (int w = 0; w < WPL; w++)
        if (off == OFF_W'(w)) m_line[idx][w*WORD_W +: WORD_W] <= req_wdata;
  end
endmodule

// File: rtl/vc_dm_cache_chk.sv
module vc_dm_cache_chk #(
  parameter int ADDR_W = 12,
  parameter int VICT_N = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ready,
  input logic              mem_req,
  input logic              mem_rsp_valid,
  input logic              waiting,
  input logic              m_hit,
  input logic              v_hit,
  input logic [VICT_N-1:0] v_match
);
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid); // R10
  AST_VICT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(v_match)); // R2
  AST_NO_FILL_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !waiting && (m_hit || v_hit)) |=> !mem_req); // R3
  AST_VHIT_SECOND_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !waiting && !m_hit && v_hit) |=>
      (!req_valid || !$stable(req_addr) || req_ready)); // R3
  AST_FILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rsp_valid) |=> mem_req); // R5
  AST_FILL_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rsp_valid) |=>
      (!mem_req && (!req_valid || !$stable(req_addr) || req_ready))); // R5
endmodule

bind vc_dm_cache vc_dm_cache_chk #(.ADDR_W(ADDR_W), .VICT_N(VICT_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_ready(req_ready), .mem_req(mem_req), .mem_rsp_valid(mem_rsp_valid),
  .waiting(waiting), .m_hit(m_hit), .v_hit(v_hit), .v_match(v_match)
);

// File: tb/vc_dm_cache_bench.sv
`timescale 1ns/1ps
module vc_dm_cache_bench;
  localparam int ADDR_W = 8, WORD_W = 16, OFF_W = 1, IDX_W = 2, VICT_N = 4;
  localparam int LA_W = ADDR_W - OFF_W, LINE_W = WORD_W << OFF_W, SETS = 1 << IDX_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [WORD_W-1:0] req_wdata = '0;
  logic req_ready, mem_req, mem_wr;
  logic [WORD_W-1:0] rsp_rdata, mem_wr_data;
  logic [LA_W-1:0] mem_addr;
  logic [ADDR_W-1:0] mem_wr_addr;
  logic mem_rsp_valid = 1'b0;
  logic [LINE_W-1:0] mem_rsp_line = '0;

  vc_dm_cache #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
                .VICT_N(VICT_N)) u_vc_dm_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line),
    .mem_wr(mem_wr), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data));

  int errs = 0, checks = 0;
  bit done = 0;
  logic [WORD_W-1:0] mem [1 << ADDR_W];

  bit             r_mv  [SETS];
  logic [LA_W-1:0] r_mla [SETS];
  bit             r_vv  [VICT_N];
  logic [LA_W-1:0] r_vla [VICT_N];
  bit             r_vsw [VICT_N];
  bit             r_drop [1 << LA_W];
  int             r_ptr;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < SETS; i++) r_mv[i] = 0;
    for (int i = 0; i < VICT_N; i++) r_vv[i] = 0;
    r_ptr = 0;
  endtask

  // memory responder: answers after three cycles of mem_req
  int wcnt = 0;
  always @(negedge clk) begin
    if (mem_req && !mem_rsp_valid) begin
      wcnt++;
      if (wcnt == 3) begin
        wcnt = 0;
        mem_rsp_valid = 1'b1;
        for (int w = 0; w < (1 << OFF_W); w++)
          mem_rsp_line[w*WORD_W +: WORD_W] = mem[{mem_addr, OFF_W'(w)}];
      end
    end else mem_rsp_valid = 1'b0;
  end

  // class: 0 main hit, 1 buffer hit, 2 full miss
  task automatic access(input logic [ADDR_W-1:0] a, input bit wr, input logic [WORD_W-1:0] d);
    logic [LA_W-1:0] la = a[ADDR_W-1:OFF_W];
    int s = int'(la[IDX_W-1:0]);
    int cls = 2, j = -1, cyc = 0, rsp_at = -1;
    bit seen_req = 0, addr_ok = 1, via_swap = 0, was_drop = r_drop[la];
    string tg;
    if (r_mv[s] && r_mla[s] == la) cls = 0;
    else begin
      for (int i = 0; i < VICT_N; i++) if (r_vv[i] && r_vla[i] == la) j = i;
      if (j >= 0) begin
        cls = 1; via_swap = r_vsw[j];
        r_vv[j] = r_mv[s]; r_vla[j] = r_mla[s]; r_vsw[j] = 1;
      end else if (r_mv[s]) begin
        int k = -1;
        for (int i = VICT_N - 1; i >= 0; i--) if (!r_vv[i]) k = i;
        if (k < 0) begin
          k = r_ptr; r_ptr = (r_ptr + 1) % VICT_N; r_drop[r_vla[k]] = 1;
        end
        r_vv[k] = 1; r_vla[k] = r_mla[s]; r_vsw[k] = 0;
      end
      r_mv[s] = 1; r_mla[s] = la; r_drop[la] = 0;
    end
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      #1; cyc++;
      if (mem_req) begin seen_req = 1; if (mem_addr != la) addr_ok = 0; end
      if (mem_rsp_valid) rsp_at = cyc;
      if (req_ready || cyc > 40) break;
      @(negedge clk);
    end
    if (cls == 0) chk(cyc == 1 && !seen_req, "R1", "main hit latency", cyc, 1);
    else if (cls == 1) begin
      tg = via_swap ? "R4" : "R6";
      chk(cyc == 2 && !seen_req, via_swap ? "R4" : "R6", "buffer hit latency (R3)", cyc, 2);
      chk(!seen_req, "R3", "no fill on buffer hit", seen_req, 0);
    end else begin
      chk(seen_req && addr_ok && rsp_at > 0 && cyc == rsp_at + 1,
          was_drop ? "R7" : "R5", "miss completes after response", cyc, rsp_at + 1);
    end
    if (wr) begin
      chk(mem_wr && mem_wr_addr == a && mem_wr_data == d, "R8", "write-through", mem_wr_data, d);
      mem[a] = d;
    end else chk(rsp_rdata == mem[a], "R1", "read data", rsp_rdata, mem[a]);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int a = 0; a < (1 << ADDR_W); a++) mem[a] = WORD_W'(a * 16'h0123 ^ 16'h5A3C);
    for (int i = 0; i < (1 << LA_W); i++) r_drop[i] = 0;
    @(negedge clk);
    do_reset();
    #1;
    chk(!req_ready && !mem_req && !mem_wr, "R10", "idle after reset",
        {req_ready, mem_req, mem_wr}, 0);
    @(negedge clk);
    // sweep every word twice
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < (1 << ADDR_W); a++) access(ADDR_W'(a), 1'b0, '0);
    // six lines on one set: fills, empty-first insertion, rotation, drop
    for (int k = 0; k < 6; k++) access(ADDR_W'((k * SETS) << OFF_W), 1'b0, '0);
    access(ADDR_W'(0), 1'b0, '0);
    access(ADDR_W'((1 * SETS) << OFF_W), 1'b0, '0);
    access(ADDR_W'((4 * SETS) << OFF_W), 1'b0, '0);
    // random mix on 32 lines, then the full space
    for (int n = 0; n < 6000; n++) begin
      logic [ADDR_W-1:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = (n < 4000) ? {2'b00, lfsr[5:0]} : lfsr[7:0];
      access(a, lfsr[11] & lfsr[14], lfsr ^ 16'h3C3C);
    end
    // reset empties both stores
    access(ADDR_W'(8), 1'b0, '0);
    do_reset();
    begin
      int cyc = 0;
      req_valid = 1'b1; req_addr = ADDR_W'(8); req_write = 1'b0;
      #1;
      chk(!req_ready, "R9", "no hit right after reset", req_ready, 0);
      @(negedge clk); #1;
      chk(mem_req, "R9", "fill after reset", mem_req, 1);
      req_valid = 1'b0;
      @(negedge clk);
    end
    do_reset();
    access(ADDR_W'(8), 1'b0, '0);
    access(ADDR_W'(9), 1'b1, 16'hBEEF);
    access(ADDR_W'(9), 1'b0, '0);
    finish_run();
  end
endmodule